// File: doc/BRIEF.md
# Dual Timer Register Front-End

This block is a bus slave sitting in front of two down-counting timer channels. It decodes word accesses into a 4 KB window, routes load, background-load, control and interrupt-clear writes to the addressed channel, and returns read data combinationally during the access phase. Each channel raises a raw interrupt flag when its count steps to zero. The front-end gates each flag with that channel's enable bit to form a per-timer interrupt pin, and ORs the two pins into one combined interrupt.

An integration test mode lets a test register take over the interrupt pins, so that the wiring can be checked without running the counters. A small set of fixed identification bytes sits at the top of the window. The counters are simple models clocked by the bus clock. Each one advances on its own count-enable input.

Top module: `dual_timer_regs`

## Requirements
- R1: Timer 0 registers sit at base 0x000 and timer 1 at base 0x020, with word offsets load 0x00, count 0x04, control 0x08, clear 0x0C, raw flag 0x10, masked flag 0x14, background load 0x18. Load, control and background load read back their stored values, and the background-load offset returns the load register. The control register keeps bits 3:0 (bit0 run, bit1 periodic, bit2 one-shot, bit3 interrupt enable) and reads zero above them.
- R2: A load write sets both the load register and the count at the commit edge. A background-load write changes only the load register and leaves the count as it was.
- R3: A running channel decrements by one on each cycle its count-enable input is high. When it steps from 1 to 0 its raw flag sets. In the next step from zero, a free-running channel wraps to 0xFFFFFFFF and a periodic channel reloads from the load register. A one-shot channel stays at zero.
- R4: Any write to a channel's clear offset drops its raw flag and its interrupt pin by the cycle after the commit edge.
- R5: The masked flag equals the raw flag AND the enable bit, and it drives that timer's pin outside test mode. Both flags read back in bit 0 with the upper bits zero.
- R6: The combined interrupt equals the OR of the two per-timer pins.
- R7: Bit 0 of the test control word at 0xF00 enables test mode. In test mode, bits 0 and 1 of the write-only test output word at 0xF04 drive timer 0 and timer 1 pins, whatever the raw flags are. The test output word reads as zero.
- R8: The words 0xFE0, 0xFE4, ..., 0xFFC read 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in their low byte, with zero above.
- R9: Unmapped addresses read zero and ignore writes. Writes to the count and identification words are ignored, and the clear offset reads zero.
- R10: After reset each count is 0xFFFFFFFF, each load is 0, each control word is 0x8, the flags are clear, test mode is off and all pins are low.
- R11: A write commits only when select, enable and write are high together, and a setup-phase cycle alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | Write when high, read when low |
| paddr | input | 12 | Byte address in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| cnt_en | input | 2 | Per-channel count enable, bit g for timer g |
| irq_tmr | output | 2 | Per-timer interrupt pins |
| irq_any | output | 1 | Combined interrupt |

## Verification
The bench walks a periodic channel across its zero crossing and back to the load value, and a free-running channel through its wrap to all ones. A reload that used the wrong source, or a wrap that went to the load value, shows up as a wrong count read back. It checks a one-shot channel that must stay parked at zero, and a background load that must not disturb the live count. A design that wrote the count there would read back the new value at once. The bench also tests test mode with a raw flag high, to catch a pin mux that ORs the two sources instead of selecting one. It writes to the count, identification and unmapped words to show that a careless decoder does not alias them.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  localparam int DW        = 32;
  localparam int AW        = 12;
  localparam int NTMR      = 2;
  localparam int CTRL_BITS = 4;

  // per-channel word offsets (paddr[4:2])
  localparam logic [2:0] OFF_LOAD  = 3'd0;
  localparam logic [2:0] OFF_COUNT = 3'd1;
  localparam logic [2:0] OFF_CTRL  = 3'd2;
  localparam logic [2:0] OFF_CLR   = 3'd3;
  localparam logic [2:0] OFF_RAW   = 3'd4;
  localparam logic [2:0] OFF_MASK  = 3'd5;
  localparam logic [2:0] OFF_BGLD  = 3'd6;

  // word indices (paddr[11:2]) of the test and identification area
  localparam logic [9:0] W_TCTRL   = 10'h3C0;
  localparam logic [9:0] W_TOUT    = 10'h3C1;
  localparam logic [6:0] W_ID_HI   = 7'h7F;

  typedef struct packed {
    logic irq_en;
    logic oneshot;
    logic periodic;
    logic run;
  } tmr_ctrl_t;

  localparam tmr_ctrl_t CTRL_RESET = '{irq_en: 1'b1, oneshot: 1'b0, periodic: 1'b0, run: 1'b0};

  // count after one step: decrement, or reload/wrap from zero
  function automatic logic [DW-1:0] next_count(input logic [DW-1:0] cur,
                                               input logic [DW-1:0] ld,
                                               input tmr_ctrl_t   c);
    if (cur != '0)        return cur - DW'(1);
    else if (c.oneshot)   return '0;
    else if (c.periodic)  return ld;
    else                  return '1;
  endfunction

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: return 8'h04;
      3'd1: return 8'h18;
      3'd2: return 8'h14;
      3'd3: return 8'h00;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dtr_channel.sv
module dtr_channel
  import dtr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_load,
  input  logic          wr_bgload,
  input  logic          wr_ctrl,
  input  logic          wr_clr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] load_q,
  output logic [DW-1:0] count_q,
  output tmr_ctrl_t     ctrl_q,
  output logic          raw_q
);
  logic count_step;
  logic hit_zero;

  assign count_step = tick && ctrl_q.run && !(ctrl_q.oneshot && count_q == '0);
  assign hit_zero   = count_step && !wr_load && count_q == DW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= '0;
      count_q <= '1;
      ctrl_q  <= CTRL_RESET;
      raw_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(wdata[CTRL_BITS-1:0]);
      if (wr_load) begin
        load_q  <= wdata;
        count_q <= wdata;
      end else begin
        if (wr_bgload) load_q <= wdata;
        if (count_step) count_q <= next_count(count_q, load_q, ctrl_q);
      end
      if (hit_zero)    raw_q <= 1'b1;
      else if (wr_clr) raw_q <= 1'b0;
    end
  end

  assert_clear_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr && !hit_zero |=> !raw_q);
  assert_load_immediate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> count_q == $past(wdata));
  assert_bgload_keeps_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bgload && !count_step |=> $stable(count_q));
  assert_oneshot_parks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.run && ctrl_q.oneshot && count_q == '0 && !wr_load |=> count_q == '0);
endmodule

// File: rtl/dtr_irq_route.sv
module dtr_irq_route
  import dtr_pkg::*;
(
  input  logic [NTMR-1:0] raw,
  input  logic [NTMR-1:0] en,
  input  logic            test_en,
  input  logic [NTMR-1:0] test_bits,
  output logic [NTMR-1:0] masked,
  output logic [NTMR-1:0] irq,
  output logic            irq_all
);
  always_comb begin
    masked  = raw & en;
    irq     = test_en ? test_bits : masked;
    irq_all = test_en ? |test_bits : |masked;
  end
endmodule

// File: rtl/dual_timer_regs.sv
module dual_timer_regs
  import dtr_pkg::*;
(
  input  logic            pclk,
  input  logic            presetn,
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [AW-1:0]   paddr,
  input  logic [DW-1:0]   pwdata,
  output logic [DW-1:0]   prdata,
  input  logic [NTMR-1:0] cnt_en,
  output logic [NTMR-1:0] irq_tmr,
  output logic            irq_any
);
  localparam int WIDX = AW - 2;

  logic            acc_wr, acc_rd;
  logic [WIDX-1:0] word;
  logic            tmr_hit, tsel;
  logic [2:0]      roff;

  logic [DW-1:0]   load_v  [NTMR];
  logic [DW-1:0]   count_v [NTMR];
  tmr_ctrl_t       ctrl_v  [NTMR];
  logic [NTMR-1:0] raw_v, en_v, masked_v;

  logic            test_en_q;
  logic [NTMR-1:0] test_bits_q;

  assign acc_wr  = psel && penable && pwrite;
  assign acc_rd  = psel && penable && !pwrite;
  assign word    = paddr[AW-1:2];
  assign tmr_hit = (paddr[AW-1:6] == '0) && (paddr[4:2] != 3'd7);
  assign tsel    = paddr[5];
  assign roff    = paddr[4:2];

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    logic hit;
    assign hit = acc_wr && tmr_hit && (tsel == 1'(g));
    dtr_channel u_chan (
      .clk       (pclk),
      .rst_n     (presetn),
      .tick      (cnt_en[g]),
      .wr_load   (hit && roff == OFF_LOAD),
      .wr_bgload (hit && roff == OFF_BGLD),
      .wr_ctrl   (hit && roff == OFF_CTRL),
      .wr_clr    (hit && roff == OFF_CLR),
      .wdata     (pwdata),
      .load_q    (load_v[g]),
      .count_q   (count_v[g]),
      .ctrl_q    (ctrl_v[g]),
      .raw_q     (raw_v[g])
    );
    assign en_v[g] = ctrl_v[g].irq_en;
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      test_en_q   <= 1'b0;
      test_bits_q <= '0;
    end else if (acc_wr) begin
      if (word == W_TCTRL) test_en_q   <= pwdata[0];
      if (word == W_TOUT)  test_bits_q <= pwdata[NTMR-1:0];
    end
  end

  dtr_irq_route u_route (
    .raw       (raw_v),
    .en        (en_v),
    .test_en   (test_en_q),
    .test_bits (test_bits_q),
    .masked    (masked_v),
    .irq       (irq_tmr),
    .irq_all   (irq_any)
  );

  always_comb begin
    prdata = '0;
    if (acc_rd) begin
      if (tmr_hit) begin
        case (roff)
          OFF_LOAD, OFF_BGLD: prdata = load_v[tsel];
          OFF_COUNT:          prdata = count_v[tsel];
          OFF_CTRL:           prdata = DW'(ctrl_v[tsel]);
          OFF_RAW:            prdata = DW'(raw_v[tsel]);
          OFF_MASK:           prdata = DW'(masked_v[tsel]);
          default:            prdata = '0;
        endcase
      end else if (word == W_TCTRL) begin
        prdata = DW'(test_en_q);
      end else if (word[WIDX-1:3] == W_ID_HI) begin
        prdata = DW'(id_byte(word[2:0]));
      end
    end
  end

  assert_any_is_or_R6: assert property (@(posedge pclk) disable iff (!presetn)
    irq_any == |irq_tmr);
  assert_test_pins_R7: assert property (@(posedge pclk) disable iff (!presetn)
    test_en_q |-> irq_tmr == test_bits_q);
  assert_pin_needs_flag_R5: assert property (@(posedge pclk) disable iff (!presetn)
    !test_en_q && irq_tmr[0] |-> raw_v[0] && ctrl_v[0].irq_en);
endmodule

// File: tb/dual_timer_regs_test.sv
module dual_timer_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [1:0]  cnt_en = '0;
  logic [1:0]  irq_tmr;
  logic        irq_any;

  int total = 0, fails = 0;

  always #5 clk = ~clk;

  dual_timer_regs uut (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cnt_en(cnt_en),
    .irq_tmr(irq_tmr), .irq_any(irq_any));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic tick(input int which);
    @(negedge clk); cnt_en = 2'(1 << which);
    @(negedge clk); cnt_en = '0;
  endtask

  task automatic pins(input string req, input logic [1:0] t, input logic a);
    chk(req, {30'b0, irq_tmr}, {30'b0, t});
    chk(req, {31'b0, irq_any}, {31'b0, a});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    pins("R10 pins", 2'b00, 1'b0);
    for (int t = 0; t < 2; t++) begin
      rchk("R10 count", 12'(t*32 + 4), 32'hFFFF_FFFF);
      rchk("R10 load",  12'(t*32 + 0), 32'h0);
      rchk("R10 ctrl",  12'(t*32 + 8), 32'h8);
      rchk("R10 raw",   12'(t*32 + 16), 32'h0);
      rchk("R10 mask",  12'(t*32 + 20), 32'h0);
    end
    rchk("R10 test ctrl", 12'hF00, 32'h0);

    // R11 setup phase alone does nothing
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = 12'h000; pwdata = 32'hDEAD;
    @(negedge clk); psel = 0; pwrite = 0;
    rchk("R11 setup only", 12'h000, 32'h0);

    // R1 / R2 load and map
    wr(12'h000, 32'h1234_5678);
    rchk("R1 load t0", 12'h000, 32'h1234_5678);
    rchk("R2 count follows load", 12'h004, 32'h1234_5678);
    wr(12'h020, 32'h0000_00AA);
    rchk("R1 count t1", 12'h024, 32'hAA);
    rchk("R1 t0 untouched", 12'h004, 32'h1234_5678);
    wr(12'h018, 32'h55);
    rchk("R2 bg load reg", 12'h000, 32'h55);
    rchk("R1 bg reads load", 12'h018, 32'h55);
    rchk("R2 bg keeps count", 12'h004, 32'h1234_5678);
    wr(12'h008, 32'hFFFF_FFF0);
    rchk("R1 ctrl upper bits", 12'h008, 32'h0);
    wr(12'h008, 32'h7);
    rchk("R1 ctrl readback", 12'h008, 32'h7);

    // R3 periodic: load 3, steps 2,1,0,3,2
    wr(12'h000, 32'd3);
    wr(12'h008, 32'hB);
    for (int i = 0; i < 5; i++) begin
      logic [31:0] e;
      e = (i < 3) ? 32'(2 - i) : 32'(6 - i);
      tick(0);
      rchk("R3 periodic count", 12'h004, e);
    end
    rchk("R3 raw set at zero", 12'h010, 32'h1);
    pins("R5 pin from raw", 2'b01, 1'b1);

    // R4 clear
    wr(12'h00C, 32'h0);
    pins("R4 clear drops pin", 2'b00, 1'b0);
    rchk("R4 raw cleared", 12'h010, 32'h0);
    rchk("R9 clear reads zero", 12'h00C, 32'h0);

    // R5 masking, R3 free-running wrap
    wr(12'h008, 32'h1);
    wr(12'h000, 32'd1);
    tick(0);
    rchk("R3 reached zero", 12'h004, 32'h0);
    rchk("R5 raw", 12'h010, 32'h1);
    rchk("R5 masked off", 12'h014, 32'h0);
    pins("R5 masked pin", 2'b00, 1'b0);
    tick(0);
    rchk("R3 free-run wrap", 12'h004, 32'hFFFF_FFFF);
    wr(12'h008, 32'h9);
    rchk("R5 masked on", 12'h014, 32'h1);
    pins("R5 enabled pin", 2'b01, 1'b1);

    // R3 one-shot
    wr(12'h00C, 32'h0);
    wr(12'h008, 32'hD);
    wr(12'h000, 32'd2);
    tick(0); rchk("R3 oneshot 1", 12'h004, 32'd1);
    tick(0); rchk("R3 oneshot 0", 12'h004, 32'd0);
    tick(0); rchk("R3 oneshot parks", 12'h004, 32'd0);
    rchk("R3 oneshot raw", 12'h010, 32'h1);

    // R6 combined
    wr(12'h028, 32'hD);
    wr(12'h020, 32'd1);
    tick(1);
    pins("R6 both", 2'b11, 1'b1);
    wr(12'h00C, 32'h0);
    pins("R6 t1 only", 2'b10, 1'b1);
    wr(12'h02C, 32'h0);
    pins("R6 none", 2'b00, 1'b0);

    // R7 test mode with raw0 high
    wr(12'h000, 32'd1);
    tick(0);
    pins("R7 pre raw", 2'b01, 1'b1);
    wr(12'hF00, 32'h1);
    wr(12'hF04, 32'h2);
    pins("R7 test 10", 2'b10, 1'b1);
    wr(12'hF04, 32'h1);
    pins("R7 test 01", 2'b01, 1'b1);
    rchk("R7 tout write-only", 12'hF04, 32'h0);
    rchk("R7 tctrl readback", 12'hF00, 32'h1);
    wr(12'hF04, 32'h0);
    pins("R7 test overrides raw", 2'b00, 1'b0);
    wr(12'hF00, 32'h0);
    pins("R7 exit test", 2'b01, 1'b1);

    // R8 identification
    for (int k = 0; k < 8; k++) begin
      logic [31:0] e;
      case (k)
        0: e = 32'h04; 1: e = 32'h18; 2: e = 32'h14; 3: e = 32'h00;
        4: e = 32'h0D; 5: e = 32'hF0; 6: e = 32'h05; default: e = 32'hB1;
      endcase
      rchk("R8 id", 12'(12'hFE0 + 4*k), e);
    end

    // R9 ignored writes and unmapped reads
    wr(12'h004, 32'h77);
    rchk("R9 count not writable", 12'h004, 32'h0);
    wr(12'h100, 32'hFFFF);
    rchk("R9 unmapped", 12'h100, 32'h0);
    rchk("R9 gap offset", 12'h01C, 32'h0);
    rchk("R9 gap t1", 12'h03C, 32'h0);
    wr(12'hFE0, 32'h99);
    rchk("R9 id not writable", 12'hFE0, 32'h04);
    rchk("R9 near test", 12'hF08, 32'h0);
    rchk("R9 load intact", 12'h000, 32'd1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule